// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire station management bus. Software places a 16-bit register address and 16-bit write data in two holding registers. It then writes a command word that selects the framing style, the operation code, the port address, the register or device number and a start bit. The block then emits one complete management frame on the clock and data wires. It drives the data wire where the frame belongs to the master and releases it where the managed device answers. It captures the answer of a read and reports whether that read failed.

Each frame starts with a run of ones, which is the preamble. A two-bit start pattern follows, then the operation code, the five-bit port address, the five-bit register or device field, a two-bit turnaround and sixteen data bits. All fields go out most significant bit first. The management clock comes from the system clock through a fixed divider. The block moves the data wire together with each management clock rising edge and samples the answer of a read on that rising edge. The start bit doubles as the busy flag. Software polls it and issues each frame of a multi-frame sequence itself.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 (command), 0x04 (register address), 0x08 (write data), 0x0C (read data) and 0x10 (status, failure flag in bit 0). Any other offset reads 0. Writes to 0x0C and 0x10 change nothing. After reset every register reads 0.
- R2: A command write with bit 14 set while idle starts a frame. While the frame runs, command bit 14 reads 1 and bits [13:0] read back the written fields: register/device [4:0], port [9:5], opcode [11:10] and type [13:12]. Bit 14 reads 0 again once the frame has ended.
- R3: A command write that arrives while a frame runs is ignored. The stored fields do not change, the running frame is not disturbed and no second frame follows.
- R4: A frame is 32 ones, then the start pattern, the opcode, the port address, the register/device field, the turnaround and 16 data bits, all MSB first. A type field of 1 selects start pattern 01. Any other type value selects 00.
- R5: A frame that is not a read drives the turnaround as 10 and drives data throughout. With the 00 start pattern, opcode 0 sends the register-address register and opcode 1 sends the write-data register. With the 01 start pattern, every opcode except 2 sends the write-data register.
- R6: A read frame is opcode 2 with the 01 start pattern, or opcode 2 or 3 with the 00 start pattern. The output enable falls at the first turnaround bit and stays low to the end of the frame. After a successful read, the 16 sampled data bits appear at 0x0C and the status bit reads 0.
- R7: If the second turnaround bit of a read is sampled as 1, the status bit reads 1 after the frame and the read-data register keeps its previous value. Frames that are not reads leave both untouched.
- R8: Each high and each low phase of the management clock lasts MDC_HALF system clocks. The data output changes during a frame only on the same edge on which the management clock rises.
- R9: With no frame running, the management clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte offset |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Register read data for busAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value when driving |
| mdioOe | output | 1 | Data output enable |
| mdioIn | input | 1 | Data wire as seen at the pin |

## Verification
Several properties are checked on every cycle. The clock stays quiet and the wire is released when idle. Each clock phase has the right length. The data output moves only on a management clock rise. A read releases the wire only on a rise. A frame starts with the wire driven high and ends just after a clock high phase. Other behaviour shows only in the bench scenarios. These cover the bit-exact frame content for every type and opcode, the choice of data source and the turnaround pattern. They also cover the captured read value, the failed-read flag, the busy readback of the command fields, and how a command written mid-frame is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [4:0] OFS_CMD   = 5'h00;
  localparam logic [4:0] OFS_ADDR  = 5'h04;
  localparam logic [4:0] OFS_WDATA = 5'h08;
  localparam logic [4:0] OFS_RDATA = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;
  localparam int START_BIT = 14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF  = 2,
  parameter int FRAME_LEN = 64,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             mdc,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MDC_HALF - 1);
  localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(FRAME_LEN - 1);

  seqState_t state;
  logic [DIV_W-1:0] divCnt;
  logic tick, rise, fall;

  assign tick = (divCnt == DIV_LAST);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.load    = (state == ST_IDLE) && startReq;
    strobe.capture = (state == ST_SHIFT) && rise;
    strobe.shift   = (state == ST_SHIFT) && rise && (bitIdx != BIT_LAST);
    strobe.finish  = (state == ST_TAIL) && fall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      mdc    <= 1'b0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_LEAD;
            divCnt <= '0;
            mdc    <= 1'b0;
            bitIdx <= '0;
          end
        end
        default: begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) mdc <= ~mdc;
          if (state == ST_LEAD && rise) state <= ST_SHIFT;
          if (state == ST_SHIFT && rise) begin
            if (bitIdx == BIT_LAST) state <= ST_TAIL;
            else bitIdx <= bitIdx + 1'b1;
          end
          if (state == ST_TAIL && fall) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 64,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrite,
  input  logic [4:0]       busAddr,
  input  logic [15:0]      busWdata,
  output logic [15:0]      busRdata,
  input  dpStrobe_t        strobe,
  input  logic             busy,
  input  logic [IDX_W-1:0] bitIdx,
  output logic             startReq,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe
);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);

  logic [13:0] cmdReg;
  logic [15:0] addrReg, wdataReg, rdataReg, rxShift;
  logic rdErr, isRead, taBit;
  logic [FRAME_LEN-1:0] shiftReg;

  // frame assembly from the incoming command word
  logic c22Sel, readOp;
  logic [1:0] opSel, stPat, taPat;
  logic [15:0] payload;
  logic [FRAME_LEN-1:0] frameWord;

  always_comb begin
    c22Sel = (busWdata[13:12] == 2'b01);
    opSel  = busWdata[11:10];
    readOp = c22Sel ? (opSel == 2'd2) : opSel[1];
    stPat  = c22Sel ? 2'b01 : 2'b00;
    taPat  = readOp ? 2'b11 : 2'b10;
    if (readOp) payload = 16'hFFFF;
    else if (!c22Sel && opSel == 2'd0) payload = addrReg;
    else payload = wdataReg;
    frameWord = {{PRE_LEN{1'b1}}, stPat, opSel, busWdata[9:5], busWdata[4:0], taPat, payload};
  end

  assign startReq = busWrite && (busAddr == OFS_CMD) && busWdata[START_BIT] && !busy;
  assign mdioOut  = shiftReg[FRAME_LEN-1];
  assign mdioOe   = busy && !(isRead && (bitIdx >= TA1_IDX));

  always_comb begin
    case (busAddr)
      OFS_CMD:   busRdata = {1'b0, busy, cmdReg};
      OFS_ADDR:  busRdata = addrReg;
      OFS_WDATA: busRdata = wdataReg;
      OFS_RDATA: busRdata = rdataReg;
      OFS_STAT:  busRdata = {15'd0, rdErr};
      default:   busRdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      rxShift  <= '0;
      rdErr    <= 1'b0;
      isRead   <= 1'b0;
      taBit    <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (busWrite && !busy && busAddr == OFS_CMD) cmdReg <= busWdata[13:0];
      if (busWrite && busAddr == OFS_ADDR) addrReg <= busWdata;
      if (busWrite && busAddr == OFS_WDATA) wdataReg <= busWdata;

      if (strobe.load) begin
        shiftReg <= frameWord;
        isRead   <= readOp;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b0};
      end

      if (strobe.capture) begin
        if (bitIdx == TA2_IDX) taBit <= mdioIn;
        if (bitIdx >= DATA_IDX) rxShift <= {rxShift[14:0], mdioIn};
      end

      if (strobe.finish && isRead) begin
        rdErr <= taBit;
        if (!taBit) rdataReg <= rxShift;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  dpStrobe_t strobe;
  logic busy, startReq;
  logic [IDX_W-1:0] bitIdx;

  mdio_ctrl #(.MDC_HALF(MDC_HALF), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strobe(strobe),
    .busy(busy), .mdc(mdc), .bitIdx(bitIdx)
  );

  mdio_dp #(.PRE_LEN(PRE_LEN), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe), .busy(busy),
    .bitIdx(bitIdx), .startReq(startReq), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int MDC_HALF = 2
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);
  logic [15:0] halfCnt;
  logic mdcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      mdcQ    <= 1'b0;
    end else begin
      mdcQ <= mdc;
      if (!busy) halfCnt <= '0;
      else if (mdc != mdcQ) halfCnt <= 16'd1;
      else halfCnt <= halfCnt + 16'd1;
    end
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  a_r8_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(mdc)) |-> (halfCnt == 16'(MDC_HALF)));

  a_r8_data_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $rose(mdc));

  a_r6_release_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $fell(mdioOe)) |-> $rose(mdc));

  a_r4_starts_driven_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && mdioOut && !mdc));

  a_r2_ends_after_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(mdc) && !mdc));
endmodule

bind mdio_master mdio_master_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 2;
  localparam int PRE  = 32;
  localparam int FLEN = PRE + 32;
  localparam int CLK_PER = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic [4:0] busAddr = 5'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  logic [FLEN-1:0] capOut, capOe, phyBits;
  int capIdx = FLEN;
  longint lastRise = 0, prevRise = 0;
  logic [15:0] expRd = 16'd0;
  logic expErr = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mdio_master #(.MDC_HALF(HALF), .PRE_LEN(PRE)) u_mdio_master (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // device model: one falling edge per bit, mid-bit
  always @(negedge mdc) begin
    if (capIdx < FLEN) begin
      capOut[capIdx] = mdioOut;
      capOe[capIdx]  = mdioOe;
      mdioIn = phyBits[capIdx];
      capIdx++;
    end
  end

  always @(posedge mdc) begin
    prevRise = lastRise;
    lastRise = $time;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrite = 1'b1;
    busAddr  = a;
    busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      busRd(5'h00, v);
      if (!v[14]) break;
    end
  endtask

  task automatic runFrame(input logic [1:0] typ, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] addrV, input logic [15:0] wdV,
                          input logic [15:0] phyData, input logic taResp,
                          input bit poke);
    logic c22, rdOp;
    logic [15:0] payload, v;
    logic [FLEN-1:0] fr;
    int badOut, badOe;
    logic expOe;
    c22  = (typ == 2'd1);
    rdOp = c22 ? (op == 2'd2) : op[1];
    if (rdOp) payload = 16'hFFFF;
    else if (!c22 && op == 2'd0) payload = addrV;
    else payload = wdV;
    fr = {{PRE{1'b1}}, (c22 ? 2'b01 : 2'b00), op, pa, ra,
          (rdOp ? 2'b11 : 2'b10), payload};
    for (int i = 0; i < FLEN; i++) phyBits[i] = 1'b1;
    phyBits[PRE+15] = taResp;
    for (int k = 0; k < 16; k++) phyBits[PRE+16+k] = phyData[15-k];

    busWr(5'h04, addrV);
    busWr(5'h08, wdV);
    mdioIn = 1'b1;
    capIdx = 0;
    busWr(5'h00, {1'b0, 1'b1, typ, op, pa, ra});
    busRd(5'h00, v);
    check("R2", "busy bit while running", 32'(v[14]), 32'd1);
    check("R2", "command fields readback", 32'(v[13:0]), 32'({typ, op, pa, ra}));
    if (poke) begin
      repeat (100) @(negedge clk);
      busWr(5'h00, {1'b0, 1'b1, ~typ, ~op, ~pa, ~ra});
      busRd(5'h00, v);
      check("R3", "fields after write while busy", 32'(v[13:0]), 32'({typ, op, pa, ra}));
    end
    waitIdle();
    busRd(5'h00, v);
    check("R2", "busy bit after frame", 32'(v[14]), 32'd0);
    check("R4", "bits in frame", 32'(capIdx), 32'(FLEN));

    badOut = 0;
    badOe = 0;
    for (int i = 0; i < FLEN; i++) begin
      expOe = rdOp ? (i < PRE + 14) : 1'b1;
      if (capOe[i] !== expOe) badOe++;
      if (expOe && capOut[i] !== fr[FLEN-1-i]) badOut++;
    end
    check("R4", "mismatching driven bits", 32'(badOut), 32'd0);
    check(rdOp ? "R6" : "R5", "mismatching enable bits", 32'(badOe), 32'd0);
    check("R8", "MDC period in time units", 32'(lastRise - prevRise), 32'(2 * HALF * CLK_PER));

    if (rdOp) begin
      expErr = taResp;
      if (!taResp) expRd = phyData;
    end
    busRd(5'h0C, v);
    check(rdOp ? "R6" : "R7", "read data register", 32'(v), 32'(expRd));
    busRd(5'h10, v);
    check("R7", "status failure bit", 32'(v), 32'(expErr));
    check("R9", "MDC low when idle", 32'(mdc), 32'd0);
    check("R9", "enable low when idle", 32'(mdioOe), 32'd0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    check("R9", "MDC in reset", 32'(mdc), 32'd0);
    check("R9", "enable in reset", 32'(mdioOe), 32'd0);
    rstN = 1'b1;
    for (int a = 0; a < 5; a++) begin
      busRd(5'(a * 4), v);
      check("R1", "register after reset", 32'(v), 32'd0);
    end

    // register file access
    busWr(5'h04, 16'hABCD);
    busRd(5'h04, v);
    check("R1", "address register", 32'(v), 32'hABCD);
    busWr(5'h08, 16'h5A3C);
    busRd(5'h08, v);
    check("R1", "write-data register", 32'(v), 32'h5A3C);
    busWr(5'h0C, 16'hFFFF);
    busRd(5'h0C, v);
    check("R1", "read-data ignores writes", 32'(v), 32'd0);
    busWr(5'h10, 16'hFFFF);
    busRd(5'h10, v);
    check("R1", "status ignores writes", 32'(v), 32'd0);
    busRd(5'h14, v);
    check("R1", "unmapped offset", 32'(v), 32'd0);
    busWr(5'h00, 16'h2C41);
    busRd(5'h00, v);
    check("R1", "command without start", 32'(v), 32'h2C41);
    check("R9", "no frame without start", 32'(mdc | mdioOe), 32'd0);

    // sweep every type and opcode
    for (int t = 0; t < 3; t++) begin
      for (int o = 0; o < 4; o++) begin
        int k;
        k = t * 4 + o;
        runFrame(2'(t), 2'(o), 5'(k * 7 + 3), 5'(k * 11 + 1),
                 16'(16'h1000 + k * 16'h0111), 16'(16'hC0DE ^ (k * 16'h0F0F)),
                 16'(16'h8421 + k * 16'h1111), 1'b0, 1'b0);
      end
    end

    // failed read then recovery
    runFrame(2'd1, 2'd2, 5'd9, 5'd17, 16'h0, 16'h0, 16'hBEEF, 1'b1, 1'b0);
    runFrame(2'd0, 2'd3, 5'd31, 5'd0, 16'hFFFF, 16'h0, 16'h0001, 1'b1, 1'b0);
    runFrame(2'd0, 2'd2, 5'd0, 5'd31, 16'h7777, 16'h0, 16'hF00D, 1'b0, 1'b0);

    // command while busy
    runFrame(2'd1, 2'd1, 5'd21, 5'd10, 16'h0, 16'h9669, 16'h0, 1'b0, 1'b1);
    repeat (400) @(negedge clk);
    busRd(5'h00, v);
    check("R3", "no second frame", 32'(v[14]), 32'd0);
    check("R3", "clock stays idle", 32'(mdc), 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule